// File: doc/BRIEF.md
# Duplex Grid/Segment Dimming Timer

This block times a two-grid multiplexed fluorescent display from a free-running oscillator clock. Four oscillator cycles make one tick and 4096 ticks make one frame. Grid 1 owns the first half of the frame and grid 2 the second half. In each half the block lights that grid for a programmed number of ticks and presents the 30-bit segment word that belongs to it. A fixed tail at the end of every half keeps both grids dark, and the segment lines are also cleared during this tail. This gives clean hand-over between the grids.

The on-time of each half depends on a day/night input. In day mode the grid is at its maximum on-time of 2032 ticks. In night mode the on-time comes from one of two sources, picked by a select input:
- an 11-bit digital level, which saturates at the maximum;
- a 6-bit step code from an external converter, which is mapped through a stepped curve with a ceiling of 256 ticks.

The chosen on-time is captured only at frame boundaries. A low test input lights everything. A monitor output shows the dimming pulse.

Top module: `duplex_dim_timer`

## Requirements
- R1: One tick lasts exactly 4 clock cycles. A frame is 4096 ticks. Grid 1 (`grid1_no`, active low) can be lit only in ticks 0..2047 of the frame, and grid 2 (`grid2_no`) only in ticks 2048..4095. The two grids are never lit together.
- R2: In day mode (`night_i` = 0), each grid is lit in ticks 0..2031 of its half and dark in the final 16 ticks of that half.
- R3: `seg_o` carries `seg_word1_i` during the first half of the frame and `seg_word2_i` during the second half. `seg_o` is forced to all zeros in ticks 2038..2047 of each half. Both grids are dark throughout those ticks.
- R4: In night mode with `dig_sel_i` = 1, the on-time per half is N ticks for `dig_level_i` = N. Any N above 2032 gives 2032 ticks. N = 0 leaves both grids dark for the whole frame.
- R5: In night mode with `dig_sel_i` = 0, the on-time per half follows step code s on `ana_step_i`:
  - s = 0 gives 0 ticks;
  - s in 1..12 gives s+12 ticks;
  - s in 13..26 gives 2s ticks;
  - s in 27..36 gives 4s-48 ticks;
  - s in 37..48 gives 8s-192 ticks;
  - s in 49..52 gives 16s-576 ticks;
  - s above 52 gives 256 ticks.
- R6: A change to `night_i`, `dig_sel_i`, `dig_level_i` or `ana_step_i` first takes effect in the frame after the change. The reset state, and the whole first frame after reset, are at tick 0 with the day on-time of 2032.
- R7: While `test_ni` is low, `seg_o` is all ones and both grid outputs are low, whatever the rest of the block is doing.
- R8: Outside test mode, `pwm_o` is high exactly when one of the grids is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| night_i | input | 1 | 1 = night mode (dimmed), 0 = day mode |
| dig_sel_i | input | 1 | Night source: 1 = digital level, 0 = step code |
| dig_level_i | input | 11 | Digital on-time level |
| ana_step_i | input | 6 | Step code from the external converter |
| test_ni | input | 1 | Active-low test input: lights all outputs |
| seg_word1_i | input | 30 | Segment word shown with grid 1 |
| seg_word2_i | input | 30 | Segment word shown with grid 2 |
| grid1_no | output | 1 | Grid 1 drive, low = lit |
| grid2_no | output | 1 | Grid 2 drive, low = lit |
| seg_o | output | 30 | Segment outputs, high = lit |
| pwm_o | output | 1 | Dimming pulse monitor |

## Verification
The bench runs nine frames. Each frame uses a different on-time source and value:
- day mode;
- digital levels 100, 2047 (the clamp) and 0;
- step codes 40, 1, 63 (the ceiling) and 28;
- a return to day mode.

Each frame is probed on both sides of the grid-off edge, so an off-by-one in the on-time compare or a wrong table segment shows up as a wrong grid level at one exact tick. Probes around ticks 2032, 2038 and 2048 separate the grid tail from the segment tail and from the word swap. A value changed mid-frame is probed later in that same frame, which shows whether the frame-boundary capture is missing. A short test-mode pulse is checked inside the pulse and after it, to confirm the override and its release.

// File: rtl/dimtm_pkg.sv
package dimtm_pkg;

  // Stepped on-time curve for the analog source, in ticks per half.
  function automatic int unsigned step_to_ticks(input int unsigned s);
    int unsigned t;
    if (s == 0)       t = 0;
    else if (s <= 12) t = s + 12;
    else if (s <= 26) t = 2 * s;
    else if (s <= 36) t = 4 * s - 48;
    else if (s <= 48) t = 8 * s - 192;
    else if (s <= 52) t = 16 * s - 576;
    else              t = 256;
    return t;
  endfunction

endpackage

// File: rtl/dimtm_tick_gen.sv
module dimtm_tick_gen #(
  parameter int CLK_PER_TICK = 4,
  parameter int POS_W        = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int PRE_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [POS_W-1:0] pos_q, pos_d;

  assign tick_o = (pre_q == PRE_W'(CLK_PER_TICK - 1));

  always_comb begin
    pre_d = tick_o ? '0 : pre_q + PRE_W'(1);
    pos_d = tick_o ? pos_q + POS_W'(1) : pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      pos_q <= '0;
    end else begin
      pre_q <= pre_d;
      pos_q <= pos_d;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/dimtm_duty_sel.sv
module dimtm_duty_sel #(
  parameter int DIG_W   = 11,
  parameter int STEP_W  = 6,
  parameter int WIDTH_W = 12,
  parameter int FULL_ON = 2032
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               night_i,
  input  logic               dig_sel_i,
  input  logic [DIG_W-1:0]   dig_level_i,
  input  logic [STEP_W-1:0]  ana_step_i,
  output logic [WIDTH_W-1:0] width_o
);
  import dimtm_pkg::*;

  localparam logic [WIDTH_W-1:0] FULL_W = WIDTH_W'(FULL_ON);

  logic [WIDTH_W-1:0] dig_w, ana_w, target, width_q, width_d;

  always_comb begin
    dig_w = WIDTH_W'(dig_level_i);
    if (dig_w > FULL_W) dig_w = FULL_W;
    ana_w = WIDTH_W'(step_to_ticks(int'(ana_step_i)));
    if (!night_i)       target = FULL_W;
    else if (dig_sel_i) target = dig_w;
    else                target = ana_w;
    width_d = load_i ? target : width_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) width_q <= FULL_W;
    else        width_q <= width_d;
  end

  assign width_o = width_q;
endmodule

// File: rtl/dimtm_drive.sv
module dimtm_drive #(
  parameter int SEG_W      = 30,
  parameter int POS_W      = 12,
  parameter int WIDTH_W    = 12,
  parameter int HALF_TICKS = 2048,
  parameter int SEG_TAIL   = 10
) (
  input  logic [POS_W-1:0]   pos_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic [SEG_W-1:0]   word1_i,
  input  logic [SEG_W-1:0]   word2_i,
  input  logic               test_ni,
  output logic               grid1_no,
  output logic               grid2_no,
  output logic [SEG_W-1:0]   seg_o,
  output logic               pwm_o
);
  localparam int HP_W = POS_W - 1;
  localparam logic [HP_W-1:0] SEG_END = HP_W'(HALF_TICKS - SEG_TAIL);

  logic            second;
  logic [HP_W-1:0] hp;
  logic            lit, seg_live;

  always_comb begin
    second   = pos_i[POS_W-1];
    hp       = pos_i[HP_W-1:0];
    lit      = ({1'b0, hp} < width_i);
    seg_live = (hp < SEG_END);
    pwm_o    = lit;
    if (!test_ni) begin
      grid1_no = 1'b0;
      grid2_no = 1'b0;
      seg_o    = '1;
    end else begin
      grid1_no = !(lit && !second);
      grid2_no = !(lit && second);
      seg_o    = seg_live ? (second ? word2_i : word1_i) : '0;
    end
  end
endmodule

// File: rtl/duplex_dim_timer.sv
module duplex_dim_timer #(
  parameter int CLK_PER_TICK = 4,
  parameter int HALF_TICKS   = 2048,
  parameter int GUARD        = 16,
  parameter int SEG_LEAD     = 6,
  parameter int SEG_W        = 30,
  parameter int DIG_W        = 11,
  parameter int STEP_W       = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              night_i,
  input  logic              dig_sel_i,
  input  logic [DIG_W-1:0]  dig_level_i,
  input  logic [STEP_W-1:0] ana_step_i,
  input  logic              test_ni,
  input  logic [SEG_W-1:0]  seg_word1_i,
  input  logic [SEG_W-1:0]  seg_word2_i,
  output logic              grid1_no,
  output logic              grid2_no,
  output logic [SEG_W-1:0]  seg_o,
  output logic              pwm_o
);
  localparam int POS_W    = $clog2(HALF_TICKS) + 1;
  localparam int WIDTH_W  = POS_W;
  localparam int FULL_ON  = HALF_TICKS - GUARD;
  localparam int SEG_TAIL = GUARD - SEG_LEAD;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_s1, rst_sync;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  logic               tick;
  logic [POS_W-1:0]   pos;
  logic [WIDTH_W-1:0] width_q;
  logic               frame_end;

  dimtm_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK), .POS_W(POS_W)) u_tick (
    .clk(clk_i), .rst_n(rst_sync), .tick_o(tick), .pos_o(pos)
  );

  assign frame_end = tick && (pos == '1);

  dimtm_duty_sel #(
    .DIG_W(DIG_W), .STEP_W(STEP_W), .WIDTH_W(WIDTH_W), .FULL_ON(FULL_ON)
  ) u_duty (
    .clk(clk_i), .rst_n(rst_sync), .load_i(frame_end),
    .night_i(night_i), .dig_sel_i(dig_sel_i),
    .dig_level_i(dig_level_i), .ana_step_i(ana_step_i),
    .width_o(width_q)
  );

  dimtm_drive #(
    .SEG_W(SEG_W), .POS_W(POS_W), .WIDTH_W(WIDTH_W),
    .HALF_TICKS(HALF_TICKS), .SEG_TAIL(SEG_TAIL)
  ) u_drive (
    .pos_i(pos), .width_i(width_q), .word1_i(seg_word1_i), .word2_i(seg_word2_i),
    .test_ni(test_ni), .grid1_no(grid1_no), .grid2_no(grid2_no),
    .seg_o(seg_o), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/dimtm_checker.sv
module dimtm_checker #(
  parameter int POS_W    = 12,
  parameter int WIDTH_W  = 12,
  parameter int SEG_W    = 30,
  parameter int SEG_FROM = 2038
) (
  input logic               clk,
  input logic               rst_n,
  input logic               test_n,
  input logic               g1n,
  input logic               g2n,
  input logic [SEG_W-1:0]   seg,
  input logic               pwm,
  input logic               tick,
  input logic [POS_W-1:0]   pos,
  input logic [WIDTH_W-1:0] width
);
  a_r1_grids_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    test_n |-> (g1n || g2n));

  a_r1_pos_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> $past(tick));

  a_r3_tail_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (test_n && (pos[POS_W-2:0] >= (POS_W-1)'(SEG_FROM))) |-> (seg == '0 && g1n && g2n));

  a_r6_width_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != '0) |-> $stable(width));

  a_r7_test_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !test_n |-> (seg == '1 && !g1n && !g2n));

  a_r8_pwm_tracks_grids: assert property (@(posedge clk) disable iff (!rst_n)
    test_n |-> (pwm == (!g1n || !g2n)));
endmodule

bind duplex_dim_timer dimtm_checker #(
  .POS_W(POS_W), .WIDTH_W(WIDTH_W), .SEG_W(SEG_W), .SEG_FROM(HALF_TICKS - SEG_TAIL)
) u_chk (
  .clk(clk_i), .rst_n(rst_sync), .test_n(test_ni), .g1n(grid1_no), .g2n(grid2_no),
  .seg(seg_o), .pwm(pwm_o), .tick(tick), .pos(pos), .width(width_q)
);

// File: tb/test_duplex_dim_timer.sv
`timescale 1ns/1ps
module test_duplex_dim_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        night_i, dig_sel_i, test_ni;
  logic [10:0] dig_level_i;
  logic [5:0]  ana_step_i;
  logic [29:0] seg_word1_i, seg_word2_i;
  logic        grid1_no, grid2_no, pwm_o;
  logic [29:0] seg_o;

  localparam logic [29:0] WA = 30'h15A5_0F0F;
  localparam logic [29:0] WB = 30'h2C3C_7E81;
  localparam int FR = 4096;

  always #5 clk_i = ~clk_i;

  duplex_dim_timer i_duplex_dim_timer (
    .clk_i, .rst_ni, .night_i, .dig_sel_i, .dig_level_i, .ana_step_i, .test_ni,
    .seg_word1_i, .seg_word2_i, .grid1_no, .grid2_no, .seg_o, .pwm_o
  );

  typedef struct {
    int unsigned c;
    logic g1n, g2n, pwm;
    logic [29:0] seg;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  int unsigned cyc = 0;
  bit   released = 0;

  // On-time per frame, taken from the requirements for the stimulus below.
  int unsigned wid [0:8] = '{2032, 100, 2032, 0, 128, 13, 256, 64, 2032};

  always @(posedge clk_i) if (released) cyc <= cyc + 1;

  task automatic push(input int unsigned t, input bit forced, input string req);
    exp_t e;
    int unsigned p, hp, w;
    bit sec, lit;
    p   = t % FR;
    sec = (p >= 2048);
    hp  = p % 2048;
    w   = wid[t / FR];
    lit = (hp < w);
    e.c = 3 + 4 * t;
    e.req = req;
    if (forced) begin
      e.g1n = 0; e.g2n = 0; e.seg = '1; e.pwm = lit;
    end else begin
      e.g1n = !(lit && !sec);
      e.g2n = !(lit && sec);
      e.seg = (hp >= 2038) ? '0 : (sec ? WB : WA);
      e.pwm = lit;
    end
    q.push_back(e);
  endtask

  task automatic compare(input string req, input logic g1n, input logic g2n,
                         input logic [29:0] seg, input logic pwm);
    n_run++;
    if (grid1_no !== g1n || grid2_no !== g2n || seg_o !== seg || pwm_o !== pwm) begin
      n_fail++;
      $display("FAIL %s: got g1n=%b g2n=%b seg=%h pwm=%b, expected g1n=%b g2n=%b seg=%h pwm=%b",
               req, grid1_no, grid2_no, seg_o, pwm_o, g1n, g2n, seg, pwm);
    end
  endtask

  // Monitor: pop and compare when the scheduled cycle comes up.
  always @(negedge clk_i) begin
    if (released && q.size() != 0 && q[0].c == cyc) begin
      exp_t e;
      e = q.pop_front();
      compare(e.req, e.g1n, e.g2n, e.seg, e.pwm);
    end
  end

  task automatic at_tick(input int unsigned t);
    while (cyc < 3 + 4 * t) @(posedge clk_i);
    #1;
  endtask

  initial begin
    rst_ni = 0; night_i = 0; dig_sel_i = 0; dig_level_i = '0; ana_step_i = '0;
    test_ni = 1; seg_word1_i = WA; seg_word2_i = WB;

    // Frame 0: day mode
    push(0, 0, "R6 reset start");
    push(2031, 0, "R2 g1 last lit"); push(2032, 0, "R2 g1 tail");
    push(2037, 0, "R3 seg before tail"); push(2038, 0, "R3 seg tail");
    push(2047, 0, "R3 seg tail end"); push(2048, 0, "R1 g2 start word2");
    push(4079, 0, "R2 g2 last lit"); push(4080, 0, "R2 g2 tail");
    push(4086, 0, "R3 g2 seg tail");
    // Frame 1: digital 100, changed mid-frame
    push(FR+99, 0, "R4 level 100 lit"); push(FR+100, 0, "R4 level 100 off");
    push(FR+150, 0, "R6 mid-frame change held");
    push(FR+2147, 0, "R4 g2 lit"); push(FR+2148, 0, "R8 g2 off");
    // Frame 2: clamp
    push(2*FR+2031, 0, "R4 clamp lit"); push(2*FR+2032, 0, "R4 clamp off");
    // Frame 3: zero
    push(3*FR, 0, "R4 zero dark"); push(3*FR+3000, 0, "R4 zero dark g2");
    // Frame 4..7: step codes
    push(4*FR+127, 0, "R5 step40 lit"); push(4*FR+128, 0, "R5 step40 off");
    push(4*FR+2175, 0, "R5 step40 g2 lit"); push(4*FR+2176, 0, "R5 step40 g2 off");
    push(5*FR+12, 0, "R5 step1 lit"); push(5*FR+13, 0, "R5 step1 off");
    push(6*FR+255, 0, "R5 step63 lit"); push(6*FR+256, 0, "R5 step63 off");
    push(7*FR+63, 0, "R5 step28 lit"); push(7*FR+64, 0, "R5 step28 off");
    // Frame 8: day again and test pulse
    push(8*FR+499, 0, "R2 day again");
    push(8*FR+550, 1, "R7 test forced");
    push(8*FR+650, 0, "R7 test released");

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    compare("R6 in reset", 1'b0, 1'b1, WA, 1'b1);
    rst_ni = 1; released = 1;

    at_tick(100);        night_i = 1; dig_sel_i = 1; dig_level_i = 11'd100;
    at_tick(FR+100);     dig_level_i = 11'd2047;
    at_tick(2*FR+100);   dig_level_i = 11'd0;
    at_tick(3*FR+100);   dig_sel_i = 0; ana_step_i = 6'd40;
    at_tick(4*FR+2200);  ana_step_i = 6'd1;
    at_tick(5*FR+100);   ana_step_i = 6'd63;
    at_tick(6*FR+300);   ana_step_i = 6'd28;
    at_tick(7*FR+100);   night_i = 0;
    at_tick(8*FR+500);   test_ni = 0;
    at_tick(8*FR+600);   test_ni = 1;

    while (q.size() != 0 && cyc < 180000) @(negedge clk_i);
    if (q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: %0d checks pending, expected 0", q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule